// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns their full-width signed product. It uses radix-2 Booth recoding. A start pulse captures the multiplicand and the multiplier. The block then runs one add-or-subtract-and-shift step per operand bit on a single working register. That register holds a sign-extended accumulator half, the multiplier, and one appended history bit.

When the last step has run, the block raises a one-cycle done pulse. In the same cycle it updates a product register, and that register keeps its value until the next operation completes. While an operation is in flight, a new start is not taken. In the cycle that done is high the block is idle again, so a new start can be issued back to back.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` and `product` go to 0 at that edge.
- R2: A `start` seen at a clock edge while the block is idle captures `mcand` and `mplier` at that edge. The working register is loaded with zeros in the accumulator half, the multiplier in the middle and a 0 history bit at bit 0.
- R3: On each step the two lowest working bits pick the action on the accumulator half: 01 adds the multiplicand, 10 subtracts it, and 00 or 11 leave it unchanged.
- R4: After the add or subtract, the whole working register shifts right by one with the accumulator sign bit replicated. `product` then equals the signed product `mcand * mplier` for every pair of signed 16-bit values, including -32768 × -32768 = 1073741824, zero operands, and -1 times any value.
- R5: The accumulator half is one bit wider than an operand, so a most-negative multiplicand is handled without overflow (-32768 × -1 = 32768, -32768 × 1 = -32768).
- R6: Exactly OP_W steps run. `done` is high for one cycle only, during the cycle that follows the (OP_W+1)-th clock edge counted from the accepting edge.
- R7: A `start` seen while an operation is in flight is ignored. The running result is not changed, and no extra `done` pulse appears.
- R8: `product` changes only at the edge that raises `done`. It holds its value between completions.
- R9: A `start` given in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mcand | input | OP_W | Signed multiplicand |
| mplier | input | OP_W | Signed multiplier |
| done | output | 1 | One-cycle pulse: product just updated |
| product | output | 2*OP_W | Signed product, held between completions |

## Verification
Two functions can meet in one cycle: the completion pulse of one operation and the acceptance of the next start. The bench provokes this by driving a new start in exactly the cycle where `done` is high. The scoreboard then expects the first product at its completion and the second product exactly OP_W+1 cycles later, with no lost or duplicated pulse. A second case puts a start in the middle of an operation, and the bench checks that neither the pending result nor the pulse count changes.

// File: rtl/booth_pkg.sv
// Package: shared types for the sequential Booth multiplier.
// Assumes: radix-2 recoding only, so three actions are enough.
package booth_pkg;
    typedef enum logic [1:0] {
        BOOTH_HOLD = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
// Module: booth_recode
// Maps the two lowest working-register bits to an accumulator action.
// Assumes: pair[0] is the history bit and pair[1] is the current multiplier bit.
module booth_recode
    import booth_pkg::*;
(
    input  logic [1:0] pair,
    output booth_op_e  op
);
    // Select add, subtract or hold from the bit pair
    always_comb begin
        case (pair)
            2'b01:   op = BOOTH_ADD;
            2'b10:   op = BOOTH_SUB;
            default: op = BOOTH_HOLD;
        endcase
    end
endmodule

// File: rtl/booth_acc_step.sv
// Module: booth_acc_step
// Applies one recoded action to the accumulator half.
// Assumes: ACC_W = OP_W + 1, so the sign-extended multiplicand never overflows.
module booth_acc_step
    import booth_pkg::*;
#(
    parameter int OP_W = 16,
    localparam int ACC_W = OP_W + 1
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [OP_W-1:0]  mcand,
    input  booth_op_e        op,
    output logic [ACC_W-1:0] acc_out
);
    logic [ACC_W-1:0] mcand_ext;

    // Sign-extend the multiplicand to accumulator width
    always_comb mcand_ext = {mcand[OP_W-1], mcand};

    // Add, subtract or pass the accumulator
    always_comb begin
        case (op)
            BOOTH_ADD: acc_out = acc_in + mcand_ext;
            BOOTH_SUB: acc_out = acc_in - mcand_ext;
            default:   acc_out = acc_in;
        endcase
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
// Module: booth_seq_ctrl
// Step sequencer: accepts a start when idle, counts OP_W steps, pulses done.
// Assumes: start is sampled only while idle; done is high in an idle cycle.
module booth_seq_ctrl #(
    parameter int OP_W = 16,
    localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic busy,
    output logic last,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    // Accept a start only while idle
    always_comb load = start && !busy;
    // Final step of the current operation
    always_comb last = busy && (cnt_q == CNT_W'(OP_W - 1));

    // Busy flag and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            busy  <= !last;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // One-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last;
    end
endmodule

// File: rtl/booth_seq_mult.sv
// Module: booth_seq_mult (top)
// Multi-cycle signed multiplier using radix-2 Booth recoding on one combined
// {accumulator, multiplier, history bit} register, one step per clock.
// Assumes: operands are two's complement; the product register is updated
// only at completion and held otherwise.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int OP_W = 16,
    localparam int ACC_W  = OP_W + 1,
    localparam int REG_W  = ACC_W + OP_W + 1,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplier,
    output logic              done,
    output logic [PROD_W-1:0] product
);
    logic              load;
    logic              busy;
    logic              last;
    logic [REG_W-1:0]  work_q;
    logic [OP_W-1:0]   mcand_q;
    logic [ACC_W-1:0]  acc_nx;
    logic [REG_W-1:0]  shifted;
    booth_op_e         op;

    booth_seq_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .busy  (busy),
        .last  (last),
        .done  (done)
    );

    booth_recode u_recode (
        .pair (work_q[1:0]),
        .op   (op)
    );

    booth_acc_step #(.OP_W(OP_W)) u_acc (
        .acc_in  (work_q[REG_W-1 -: ACC_W]),
        .mcand   (mcand_q),
        .op      (op),
        .acc_out (acc_nx)
    );

    // Arithmetic right shift of the updated register
    always_comb shifted = {acc_nx[ACC_W-1], acc_nx, work_q[OP_W:1]};

    // Working register: load on accepted start, step while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '0;
            mcand_q <= '0;
        end else if (load) begin
            work_q  <= {{ACC_W{1'b0}}, mplier, 1'b0};
            mcand_q <= mcand;
        end else if (busy) begin
            work_q  <= shifted;
        end
    end

    // Product register: captured on the final step only
    always_ff @(posedge clk) begin
        if (!rst_n)    product <= '0;
        else if (last) product <= shifted[PROD_W:1];
    end
endmodule

// File: rtl/booth_seq_mult_chk.sv
// Module: booth_seq_mult_chk
// Timing and protocol checker, bound to booth_seq_mult.
// Assumes: busy is the internal in-flight flag of the top module.
module booth_seq_mult_chk #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W,
    localparam int LAT    = OP_W + 1,
    localparam int LAT_W  = $clog2(LAT + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [PROD_W-1:0] product
);
    logic [LAT_W-1:0] lat_q;

    // Count cycles since the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)                    lat_q <= '0;
        else if (start && !busy)       lat_q <= LAT_W'(1);
        else if (lat_q == LAT_W'(LAT)) lat_q <= '0;
        else if (lat_q != '0)          lat_q <= lat_q + LAT_W'(1);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!done && product == '0)); // R1
    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n) done |-> lat_q == LAT_W'(LAT)); // R6
    AST_DONE_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n) lat_q == LAT_W'(LAT) |-> done); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(product) |-> done); // R8
    AST_START_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && lat_q != '0 && lat_q < LAT_W'(OP_W)) |=> (busy && lat_q != LAT_W'(1))); // R7
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.OP_W(OP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mult_bench.sv
// Scoreboard bench: the driver pushes expected products and due cycles,
// and the monitor pops and compares them whenever done is seen.
module booth_seq_mult_bench;
    localparam int OP_W = 16;
    localparam int PROD_W = 2 * OP_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [OP_W-1:0]   mcand = '0;
    logic [OP_W-1:0]   mplier = '0;
    logic              done;
    logic [PROD_W-1:0] product;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stab_bad = 0;
    int extra_done = 0;
    logic [PROD_W-1:0] exp_q[$];
    int                due_q[$];
    logic [PROD_W-1:0] last_prod = '0;
    logic              mon_on = 1'b0;

    booth_seq_mult #(.OP_W(OP_W)) u_booth_seq_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .done    (done),
        .product (product)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: issue one operation and push its expectation
    task automatic issue(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        int ia;
        int ib;
        @(negedge clk);
        ia = int'($signed(a));
        ib = int'($signed(b));
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        exp_q.push_back(PROD_W'(ia * ib));
        due_q.push_back(cyc + OP_W + 1);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for the scoreboard to drain
    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare results at completion, watch for stray pulses
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    extra_done++;
                    check(1'b0, "R7 unexpected done", 64'(product), 64'(0));
                end else begin
                    logic [PROD_W-1:0] e;
                    int d;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    check(product == e, "R4 product", 64'(product), 64'(e));
                    check(cyc == d, "R6 latency", 64'(cyc), 64'(d));
                end
            end else if (product != last_prod) begin
                stab_bad++;
            end
            last_prod = product;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        check(done == 1'b0, "R1 done after reset", 64'(done), 64'(0));
        check(product == '0, "R1 product after reset", 64'(product), 64'(0));
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 R3 R4: directed patterns
        issue(16'd3, 16'd5);
        drain();
        issue(16'd0, 16'h1234);
        drain();
        issue(16'h7FFF, 16'd0);
        drain();
        issue(16'hFFFF, 16'd12345);      // -1 x value
        drain();
        issue(16'd777, 16'hFFFF);        // value x -1, all-ones pair run
        drain();
        issue(16'hFFFF, 16'hFFFF);
        drain();
        issue(16'h8000, 16'h8000);       // R4: -32768 x -32768
        drain();
        issue(16'h8000, 16'hFFFF);       // R5
        drain();
        issue(16'h8000, 16'd1);          // R5
        drain();
        issue(16'h7FFF, 16'h7FFF);
        drain();
        issue(16'hAAAA, 16'h5555);       // R3: alternating pairs
        drain();

        // R9: back-to-back, start in the done cycle
        issue(16'd100, 16'hFF9C);
        repeat (OP_W - 1) @(negedge clk);
        issue(16'h1357, 16'h2468);
        repeat (OP_W - 1) @(negedge clk);
        issue(16'hC001, 16'h0FF0);
        drain();

        // R7: start while busy is ignored
        issue(16'd21, 16'd2);
        repeat (4) @(negedge clk);
        start = 1'b1; mcand = 16'h4000; mplier = 16'h4000;
        repeat (3) @(negedge clk);
        start = 1'b0; mcand = '0; mplier = '0;
        drain();
        repeat (OP_W + 4) @(negedge clk);
        check(extra_done == 0, "R7 no extra done", 64'(extra_done), 64'(0));

        // R4: pseudo-random operands from an LFSR
        begin
            logic [31:0] lf;
            lf = 32'hACE1_2468;
            for (int k = 0; k < 40; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                issue(lf[15:0], lf[31:16]);
                drain();
            end
        end

        // R8: product held between completions
        check(stab_bad == 0, "R8 product stable", 64'(stab_bad), 64'(0));
        check(exp_q.size() == 0, "R6 all results seen", 64'(exp_q.size()), 64'(0));
        summary();
        $finish;
    end
endmodule